// File: doc/BRIEF.md
# UART FIFO threshold interrupt unit

This block sits between a UART's serial bit engine and its register interface. It keeps two byte FIFOs: one filled by the receive engine and drained by the bus side, one filled by the bus side and drained by the transmit engine. Both fill counts are reported continuously. Programmable thresholds on those counts raise interrupts, pull down a receive flow-control request, and drive an idle timer that counts byte times while received data sits unread.

Nine interrupt sources are kept in a bank with raw, enable, masked status and write-one-to-clear views. Four of them come from inside the block: receive level, transmit level, receive overflow and receive idle. The remaining five are single-cycle pulses from the bit engine or the modem-line logic. Both data paths use valid/ready. The receive input never back-pressures: its ready output is always high, and a byte offered while the receive FIFO is full is dropped and recorded as an overflow. The transmit input drops ready while its FIFO is full, and the producer must hold the byte until ready returns. On both output sides, valid means the FIFO is non-empty. The data output shows the oldest byte, and a byte leaves the FIFO on a cycle where valid and ready are both high.

Top module: `uart_fifo_irq`

## Requirements
- R1: Each FIFO holds DEPTH (128) bytes and returns them in the order they were written. The counts `rx_count` and `tx_count` are 8 bits wide. `tx_in_ready` is low only when the transmit count equals DEPTH, and a transmit byte offered while ready is low does not change the count. `rx_in_ready` is always high. Output valid is high exactly when the count is non-zero.
- R2: Interrupt bit 0 (receive level) becomes set one cycle after `rx_count` is greater than or equal to `rx_full_thr`.
- R3: Interrupt bit 1 (transmit level) becomes set one cycle after `tx_count` is less than or equal to `tx_empty_thr`.
- R4: A one-cycle pulse on an event input sets its raw bit on the following clock edge: `evt_parity` sets bit 2, `evt_frame` sets bit 3, `evt_dsr_chg` sets bit 5, `evt_cts_chg` sets bit 6 and `evt_brk` sets bit 7.
- R5: A receive byte offered while the receive FIFO holds DEPTH bytes is discarded. The count and the stored contents are unchanged, and raw bit 4 becomes set on that edge.
- R6: `irq_status` equals `irq_raw` masked bitwise by `irq_ena`, and `irq` is high when any status bit is high. Both follow the enable input with no extra cycle.
- R7: A 1 in `irq_clr` clears the matching raw bit on that edge, and a clear takes priority over a set arriving on the same edge. A level source whose condition still holds sets its bit again on the next edge.
- R8: When `rx_idle_en` is high and the receive FIFO is not empty, raw bit 8 becomes set one cycle after the idle counter reaches `rx_idle_thr`. The idle counter advances by one for each `byte_tick` pulse and saturates at its maximum value.
- R9: The idle counter returns to zero when a receive byte is accepted, when a receive byte is popped, or when the receive FIFO is cleared.
- R10: `rts_req` is low while `rx_flow_en` is high and `rx_count` is greater than or equal to `rx_flow_thr`. Otherwise it is high. It follows the count with no added cycle.
- R11: When `rx_fifo_clr` or `tx_fifo_clr` is high on a clock edge, the corresponding FIFO is emptied, and this overrides any push or pop on that edge.
- R12: Reset empties both FIFOs, clears all raw bits and leaves `rts_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in_valid | input | 1 | Receive engine offers a byte |
| rx_in_ready | output | 1 | Always high; a byte offered while full is dropped |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Receive FIFO not empty |
| rx_out_ready | input | 1 | Bus side takes the oldest received byte |
| rx_out_data | output | 8 | Oldest received byte |
| tx_in_valid | input | 1 | Bus side offers a byte to send |
| tx_in_ready | output | 1 | Transmit FIFO has space |
| tx_in_data | input | 8 | Byte to send |
| tx_out_valid | output | 1 | Transmit FIFO not empty |
| tx_out_ready | input | 1 | Transmit engine takes the oldest byte |
| tx_out_data | output | 8 | Oldest byte to send |
| rx_fifo_clr | input | 1 | Empty the receive FIFO |
| tx_fifo_clr | input | 1 | Empty the transmit FIFO |
| rx_full_thr | input | 7 | Receive level threshold |
| tx_empty_thr | input | 7 | Transmit level threshold |
| rx_flow_thr | input | 7 | Flow-control threshold |
| rx_flow_en | input | 1 | Enable receive flow control |
| rx_idle_thr | input | 7 | Idle timeout in byte times |
| rx_idle_en | input | 1 | Enable idle timeout |
| byte_tick | input | 1 | One pulse per byte time |
| evt_parity | input | 1 | Parity error pulse |
| evt_frame | input | 1 | Other receive error pulse |
| evt_dsr_chg | input | 1 | DSR line change pulse |
| evt_cts_chg | input | 1 | CTS line change pulse |
| evt_brk | input | 1 | Break / start error pulse |
| irq_ena | input | 9 | Interrupt enables |
| irq_clr | input | 9 | Write-one-to-clear strobes |
| rx_count | output | 8 | Receive fill count |
| tx_count | output | 8 | Transmit fill count |
| irq_raw | output | 9 | Raw interrupt bits |
| irq_status | output | 9 | Raw masked by enable |
| irq | output | 1 | Any status bit set |
| rts_req | output | 1 | Receive flow-control request, high = send allowed |

## Verification
Counts, FIFO data and the clearing of a FIFO change on the edge that samples the push, pop or clear. `rts_req` follows the count on that same edge. Event pulses, overflow and interrupt clears reach `irq_raw` on the edge that samples them. Level-derived raw bits (R2, R3, R8) trail their condition by one further edge. `irq_status` and `irq` follow `irq_ena` combinationally. The bench drives inputs at the falling edge and samples at a later falling edge. For level bits it first checks that the bit is still low one falling edge after the condition appears, and only then checks that it has become set. This confirms the one-edge delay instead of only observing the final value.

// File: rtl/uq_pkg.sv
package uq_pkg;
  localparam int NUM_IRQ    = 9;
  localparam int IRQ_RXLVL  = 0;
  localparam int IRQ_TXLVL  = 1;
  localparam int IRQ_PARITY = 2;
  localparam int IRQ_FRAME  = 3;
  localparam int IRQ_OVF    = 4;
  localparam int IRQ_DSR    = 5;
  localparam int IRQ_CTS    = 6;
  localparam int IRQ_BRK    = 7;
  localparam int IRQ_IDLE   = 8;
endpackage

// File: rtl/uq_byte_fifo.sv
module uq_byte_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uq_idle_timer.sv
module uq_idle_timer #(
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic          en,
  input  logic          has_data,
  input  logic [TW-1:0] thr,
  output logic          expired
);
  logic [TW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      idle_cnt <= '0;
    else if (tick && idle_cnt != {TW{1'b1}})
      idle_cnt <= idle_cnt + 1'b1;
  end

  assign expired = en && has_data && (idle_cnt >= thr);
endmodule

// File: rtl/uq_irq_bank.sv
module uq_irq_bank #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] ena,
  output logic [N-1:0] raw,
  output logic [N-1:0] status,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          raw[i] <= 1'b0;
      else if (clr_vec[i]) raw[i] <= 1'b0;
      else if (set_vec[i]) raw[i] <= 1'b1;
    end
    assign status[i] = raw[i] & ena[i];
  end

  assign irq = |status;
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int THR_W = 7,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int NI   = uq_pkg::NUM_IRQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_fifo_clr,
  input  logic          tx_fifo_clr,
  input  logic [THR_W-1:0] rx_full_thr,
  input  logic [THR_W-1:0] tx_empty_thr,
  input  logic [THR_W-1:0] rx_flow_thr,
  input  logic          rx_flow_en,
  input  logic [THR_W-1:0] rx_idle_thr,
  input  logic          rx_idle_en,
  input  logic          byte_tick,
  input  logic          evt_parity,
  input  logic          evt_frame,
  input  logic          evt_dsr_chg,
  input  logic          evt_cts_chg,
  input  logic          evt_brk,
  input  logic [NI-1:0] irq_ena,
  input  logic [NI-1:0] irq_clr,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic [NI-1:0] irq_raw,
  output logic [NI-1:0] irq_status,
  output logic          irq,
  output logic          rts_req
);
  import uq_pkg::*;

  logic rx_full, rx_empty, tx_full, tx_empty;
  logic rx_pop, rx_accept, rx_drop;
  logic idle_hit;
  logic [NI-1:0] set_vec;

  assign rx_in_ready = 1'b1;
  assign rx_pop      = rx_out_ready && !rx_empty;
  assign rx_accept   = rx_in_valid && !rx_full;
  assign rx_drop     = rx_in_valid && rx_full && !rx_fifo_clr;

  uq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_fifo_clr),
    .push(rx_in_valid), .din(rx_in_data),
    .pop(rx_out_ready), .dout(rx_out_data),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  uq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_fifo_clr),
    .push(tx_in_valid), .din(tx_in_data),
    .pop(tx_out_ready), .dout(tx_out_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  assign rx_out_valid = !rx_empty;
  assign tx_out_valid = !tx_empty;
  assign tx_in_ready  = !tx_full;

  uq_idle_timer #(.TW(THR_W)) u_idle (
    .clk(clk), .rst_n(rst_n),
    .restart(rx_accept || rx_pop || rx_fifo_clr),
    .tick(byte_tick), .en(rx_idle_en), .has_data(!rx_empty),
    .thr(rx_idle_thr), .expired(idle_hit)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[IRQ_RXLVL]  = rx_count >= CW'(rx_full_thr);
    set_vec[IRQ_TXLVL]  = tx_count <= CW'(tx_empty_thr);
    set_vec[IRQ_PARITY] = evt_parity;
    set_vec[IRQ_FRAME]  = evt_frame;
    set_vec[IRQ_OVF]    = rx_drop;
    set_vec[IRQ_DSR]    = evt_dsr_chg;
    set_vec[IRQ_CTS]    = evt_cts_chg;
    set_vec[IRQ_BRK]    = evt_brk;
    set_vec[IRQ_IDLE]   = idle_hit;
  end

  uq_irq_bank #(.N(NI)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(irq_clr),
    .ena(irq_ena), .raw(irq_raw), .status(irq_status), .irq(irq)
  );

  assign rts_req = !(rx_flow_en && (rx_count >= CW'(rx_flow_thr)));
endmodule

// File: rtl/uq_checker.sv
module uq_checker #(
  parameter int DEPTH = 128,
  parameter int CW    = 8,
  parameter int NI    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_in_valid,
  input logic          rx_out_valid,
  input logic          rx_out_ready,
  input logic          tx_out_valid,
  input logic          rx_fifo_clr,
  input logic          tx_fifo_clr,
  input logic          rx_flow_en,
  input logic [NI-1:0] irq_clr,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic [NI-1:0] irq_raw,
  input logic          rts_req
);
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  // R1
  rx_push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_count < CW'(DEPTH) && !(rx_out_valid && rx_out_ready) && !rx_fifo_clr)
    |=> rx_count == $past(rx_count) + 1'b1);

  // R1
  tx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |-> !tx_out_valid);

  // R5
  rx_drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_count == CW'(DEPTH) && !rx_fifo_clr && !rx_out_ready)
    |=> irq_raw[4] && rx_count == CW'(DEPTH));

  // R7
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_clr) |=> ((irq_raw & $past(irq_clr)) == '0));

  // R11
  fifo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_clr || tx_fifo_clr)
    |=> (!$past(rx_fifo_clr) || rx_count == '0) && (!$past(tx_fifo_clr) || tx_count == '0));

  // R10
  rts_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_flow_en |-> rts_req);
endmodule

bind uart_fifo_irq uq_checker #(.DEPTH(DEPTH), .CW(CW), .NI(NI)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_in_valid(rx_in_valid),
  .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
  .tx_out_valid(tx_out_valid), .rx_fifo_clr(rx_fifo_clr),
  .tx_fifo_clr(tx_fifo_clr), .rx_flow_en(rx_flow_en), .irq_clr(irq_clr),
  .rx_count(rx_count), .tx_count(tx_count), .irq_raw(irq_raw),
  .rts_req(rts_req)
);

// File: tb/uart_fifo_irq_tb.sv
module uart_fifo_irq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       rx_in_valid = 0, rx_out_ready = 0, tx_in_valid = 0, tx_out_ready = 0;
  logic [7:0] rx_in_data = 0, tx_in_data = 0;
  logic       rx_in_ready, rx_out_valid, tx_in_ready, tx_out_valid;
  logic [7:0] rx_out_data, tx_out_data;
  logic       rx_fifo_clr = 0, tx_fifo_clr = 0;
  logic [6:0] rx_full_thr = 7'd127, tx_empty_thr = 7'd0, rx_flow_thr = 7'd127, rx_idle_thr = 7'd3;
  logic       rx_flow_en = 0, rx_idle_en = 0, byte_tick = 0;
  logic       evt_parity = 0, evt_frame = 0, evt_dsr_chg = 0, evt_cts_chg = 0, evt_brk = 0;
  logic [8:0] irq_ena = 0, irq_clr = 0;
  logic [7:0] rx_count, tx_count;
  logic [8:0] irq_raw, irq_status;
  logic       irq, rts_req;

  int n_run = 0, n_fail = 0;

  uart_fifo_irq u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
    .rx_full_thr(rx_full_thr), .tx_empty_thr(tx_empty_thr),
    .rx_flow_thr(rx_flow_thr), .rx_flow_en(rx_flow_en),
    .rx_idle_thr(rx_idle_thr), .rx_idle_en(rx_idle_en), .byte_tick(byte_tick),
    .evt_parity(evt_parity), .evt_frame(evt_frame), .evt_dsr_chg(evt_dsr_chg),
    .evt_cts_chg(evt_cts_chg), .evt_brk(evt_brk),
    .irq_ena(irq_ena), .irq_clr(irq_clr),
    .rx_count(rx_count), .tx_count(tx_count),
    .irq_raw(irq_raw), .irq_status(irq_status), .irq(irq), .rts_req(rts_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_in_valid = 1; rx_in_data = d;
    @(negedge clk);
    rx_in_valid = 0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    tx_in_valid = 1; tx_in_data = d;
    @(negedge clk);
    tx_in_valid = 0;
  endtask

  task automatic rx_pop_one();
    rx_out_ready = 1;
    @(negedge clk);
    rx_out_ready = 0;
  endtask

  task automatic tick();
    byte_tick = 1;
    @(negedge clk);
    byte_tick = 0;
  endtask

  task automatic clr_irq(input logic [8:0] m);
    irq_clr = m;
    @(negedge clk);
    irq_clr = 0;
  endtask

  task automatic flush_rx();
    rx_fifo_clr = 1;
    @(negedge clk);
    rx_fifo_clr = 0;
  endtask

  task automatic t_reset();
    check("R12 rx_count", rx_count, 0);
    check("R12 tx_count", tx_count, 0);
    check("R12 irq_raw", irq_raw, 0);
    check("R12 rts_req", rts_req, 1);
    check("R1 rx_out_valid empty", rx_out_valid, 0);
    check("R1 tx_in_ready", tx_in_ready, 1);
  endtask

  task automatic t_tx_level();
    tx_empty_thr = 7'd2;
    for (int i = 0; i < 4; i++) tx_push(8'h10 + 8'(i));
    check("R1 tx_count", tx_count, 4);
    clr_irq(9'h1FF);
    @(negedge clk);
    check("R3 tx level above thr", irq_raw[1], 0);
    for (int i = 0; i < 2; i++) begin
      check("R1 tx order", tx_out_data, 8'h10 + 8'(i));
      tx_out_ready = 1; @(negedge clk); tx_out_ready = 0;
    end
    check("R3 tx level one cycle late", irq_raw[1], 0);
    @(negedge clk);
    check("R3 tx level set", irq_raw[1], 1);
    clr_irq(9'h002);
    check("R7 clear wins", irq_raw[1], 0);
    @(negedge clk);
    check("R7 level reasserts", irq_raw[1], 1);
    tx_fifo_clr = 1; @(negedge clk); tx_fifo_clr = 0;
  endtask

  task automatic t_rx_level();
    rx_full_thr = 7'd4; irq_ena = 9'h001;
    clr_irq(9'h1FF);
    for (int i = 0; i < 3; i++) rx_push(8'(i));
    @(negedge clk);
    check("R2 below thr", irq_raw[0], 0);
    check("R6 irq low", irq, 0);
    rx_push(8'h3);
    check("R2 one cycle late", irq_raw[0], 0);
    @(negedge clk);
    check("R2 raw set", irq_raw[0], 1);
    check("R6 status", irq_status[0], 1);
    check("R6 irq", irq, 1);
    irq_ena = 0; #1;
    check("R6 masked status", irq_status[0], 0);
    check("R6 masked irq", irq, 0);
    rx_full_thr = 7'd127;
    flush_rx();
  endtask

  task automatic t_events();
    clr_irq(9'h1FF);
    for (int b = 0; b < 5; b++) begin
      int bit_i;
      bit_i = (b == 0) ? 2 : (b == 1) ? 3 : (b == 2) ? 5 : (b == 3) ? 6 : 7;
      check("R4 event idle", irq_raw[bit_i], 0);
      evt_parity = (b == 0); evt_frame = (b == 1); evt_dsr_chg = (b == 2);
      evt_cts_chg = (b == 3); evt_brk = (b == 4);
      @(negedge clk);
      evt_parity = 0; evt_frame = 0; evt_dsr_chg = 0; evt_cts_chg = 0; evt_brk = 0;
      check("R4 event set", irq_raw[bit_i], 1);
    end
  endtask

  task automatic t_overflow();
    flush_rx();
    clr_irq(9'h1FF);
    for (int i = 0; i < 128; i++) rx_push(8'(i));
    check("R1 rx full count", rx_count, 128);
    check("R1 rx ready while full", rx_in_ready, 1);
    check("R5 no overflow yet", irq_raw[4], 0);
    rx_push(8'hEE);
    check("R5 count unchanged", rx_count, 128);
    check("R5 overflow raw", irq_raw[4], 1);
    check("R5 head intact", rx_out_data, 8'h00);
    rx_pop_one();
    check("R1 rx order", rx_out_data, 8'h01);
    check("R1 rx count after pop", rx_count, 127);
    flush_rx();
    check("R11 rx cleared", rx_count, 0);
    check("R11 rx not valid", rx_out_valid, 0);
  endtask

  task automatic t_idle();
    flush_rx();
    rx_idle_thr = 7'd3; rx_idle_en = 1;
    clr_irq(9'h1FF);
    rx_push(8'hA1);
    tick(); tick();
    repeat (3) @(negedge clk);
    check("R8 two ticks idle", irq_raw[8], 0);
    rx_push(8'hA2);
    tick(); tick();
    repeat (3) @(negedge clk);
    check("R9 push restarts", irq_raw[8], 0);
    tick();
    check("R8 one cycle late", irq_raw[8], 0);
    @(negedge clk);
    check("R8 timeout set", irq_raw[8], 1);
    rx_pop_one();
    clr_irq(9'h100);
    tick(); tick();
    @(negedge clk);
    check("R9 pop restarts", irq_raw[8], 0);
    tick();
    @(negedge clk);
    check("R8 timeout after pop", irq_raw[8], 1);
    rx_idle_en = 0;
    clr_irq(9'h100);
    repeat (2) @(negedge clk);
    check("R8 disabled", irq_raw[8], 0);
    flush_rx();
  endtask

  task automatic t_rts();
    flush_rx();
    rx_flow_thr = 7'd3; rx_flow_en = 1;
    @(negedge clk);
    check("R10 empty rts", rts_req, 1);
    rx_push(8'h1); rx_push(8'h2);
    check("R10 below thr", rts_req, 1);
    rx_push(8'h3);
    check("R10 at thr", rts_req, 0);
    rx_flow_en = 0; #1;
    check("R10 flow off", rts_req, 1);
    rx_flow_en = 1; #1;
    rx_pop_one();
    check("R10 after pop", rts_req, 1);
    rx_flow_en = 0;
    flush_rx();
  endtask

  task automatic t_tx_full();
    for (int i = 0; i < 128; i++) tx_push(8'(i));
    check("R1 tx full count", tx_count, 128);
    check("R1 tx not ready", tx_in_ready, 0);
    tx_push(8'h55);
    check("R1 tx count held", tx_count, 128);
    check("R1 tx head", tx_out_data, 8'h00);
    tx_fifo_clr = 1; @(negedge clk); tx_fifo_clr = 0;
    check("R11 tx cleared", tx_count, 0);
    check("R11 tx not valid", tx_out_valid, 0);
  endtask

  logic done = 0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_tx_level();
    t_rx_level();
    t_events();
    t_overflow();
    t_idle();
    t_rts();
    t_tx_full();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule